// File: doc/BRIEF.md
# Response frame transmitter with holdoff

This block sends a device response to the host as one frame. After `start_i` it emits a single sync byte `0xAA` and then a fixed number of groups, with no length prefix. Each group is seven data bytes pulled from a source and turned into eight wire bytes. Every wire byte has its MSB set. Bytes leave through a valid/ready handshake to a downstream byte serializer. The block keeps a running sum of the data bytes. In the final group it overwrites the seventh data byte with the two's complement of that sum, so the whole payload sums to zero modulo 256.

The host can suspend the transfer at any time by dropping the link state from 1 to 0. The block first finishes the group it has started, because the host accepts that group. It then goes silent until the link state returns to 1. It resumes by sending `0xAA` again and continues with the next group. The count of groups still to send is decremented for every finished group, including the one that closes out a suspend. The frame therefore ends after exactly the requested number of groups, and `done_o` pulses once.

Top module: `resp_tx`

## Requirements
- R1: After reset `tx_valid_o`, `grp_ready_o` and `done_o` are low.
- R2: `start_i` while idle with a nonzero `n_groups_i` loads the group count and begins a frame. A start with a count of zero is ignored and sends nothing.
- R3: A frame opens with exactly one `0xAA` byte and no length bytes. Without a suspend it contains 1 + 8·N wire bytes.
- R4: Data byte k of a group is `grp_data_i[8k+7:8k]`, for k = 0 to 6. The first wire byte of a group is `1, d0[7], d1[7], …, d6[7]`, MSB first. Wire byte k+1 is `{1'b1, dk[6:0]}`.
- R5: In the last group, the source's byte 6 is replaced so that all data bytes of the frame sum to 0 modulo 256.
- R6: Exactly N groups are taken from the source and sent, including across suspends.
- R7: After a 1→0 change of `link_i`, the group in progress is completed. No byte is then offered while `link_i` stays low.
- R8: When `link_i` is 1 again, the block sends `0xAA` and then the group after the last finished one.
- R9: A suspend that begins during the final group adds no sync byte, and the frame completes normally.
- R10: `done_o` is a one-cycle pulse in the cycle after the last wire byte is accepted.
- R11: Every offered byte has its MSB set. While `tx_valid_o` is high and `tx_ready_i` is low, the byte and the valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (idle only) |
| n_groups_i | input | CNT_W | Number of groups in the frame |
| grp_valid_i | input | 1 | Source group available |
| grp_data_i | input | 8·DATA_BYTES | Group data, byte 0 in the low bits |
| grp_ready_o | output | 1 | Group taken this cycle when valid |
| link_i | input | 1 | Host protocol state: 1 communicate, 0 suspend |
| tx_valid_o | output | 1 | Wire byte offered to serializer |
| tx_byte_o | output | 8 | Wire byte |
| tx_ready_i | input | 1 | Serializer accepts the byte |
| done_o | output | 1 | Frame finished pulse |

## Verification
The assertions assume that `start_i` is raised only while the block is idle. They also assume the serializer may hold off at will, and that `link_i` changes only between clock edges. The stimulus pulses start only between frames and throttles `tx_ready_i` in a repeating pattern. It drops the link in the middle of a chosen group and keeps it low long enough for the pause to be observed before restoring it. One such drop falls in the final group, so the resync-free ending is covered.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_GRAB,
    ST_SEND,
    ST_PAUSE
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'hAA;
endpackage

// File: rtl/resp_tx_enc.sv
module resp_tx_enc #(
  parameter int DATA_BYTES = 7,
  localparam int WIRE_BYTES = DATA_BYTES + 1
) (
  input  logic [8*DATA_BYTES-1:0] grp_i,
  output logic [8*WIRE_BYTES-1:0] wire_o
);
  logic [7:0] head;

  always_comb begin
    head = 8'h80;
    for (int k = 0; k < DATA_BYTES; k++) head[DATA_BYTES-1-k] = grp_i[8*k+7];
  end

  assign wire_o[7:0] = head;

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_low
    assign wire_o[8*(k+1) +: 8] = {1'b1, grp_i[8*k +: 7]};
  end
endmodule

// File: rtl/resp_tx_csum.sv
module resp_tx_csum #(
  parameter int DATA_BYTES = 7
) (
  input  logic [8*DATA_BYTES-1:0] grp_i,
  input  logic [7:0]              sum_i,
  input  logic                    last_i,
  output logic [8*DATA_BYTES-1:0] grp_o,
  output logic [7:0]              sum_o
);
  logic [7:0] acc;
  logic [7:0] b;

  always_comb begin
    acc = sum_i;
    for (int k = 0; k < DATA_BYTES; k++) begin
      b = grp_i[8*k +: 8];
      // final slot carries the value that zeroes the payload sum
      if (last_i && k == DATA_BYTES - 1) b = 8'(~acc + 8'd1);
      grp_o[8*k +: 8] = b;
      acc = acc + b;
    end
    sum_o = acc;
  end
endmodule

// File: rtl/resp_tx_hold.sv
module resp_tx_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic clr_i,
  output logic pend_o
);
  logic link_q;
  logic fall;

  assign fall = link_q & ~link_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b1;
      pend_o <= 1'b0;
    end else begin
      link_q <= link_i;
      if (fall)       pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_tx.sv
module resp_tx
  import resp_tx_pkg::*;
#(
  parameter int DATA_BYTES = 7,
  parameter int MAX_GROUPS = 64,
  localparam int WIRE_BYTES = DATA_BYTES + 1,
  localparam int CNT_W = $clog2(MAX_GROUPS + 1),
  localparam int IDX_W = $clog2(WIRE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CNT_W-1:0]        n_groups_i,
  input  logic                    grp_valid_i,
  input  logic [8*DATA_BYTES-1:0] grp_data_i,
  output logic                    grp_ready_o,
  input  logic                    link_i,
  output logic                    tx_valid_o,
  output logic [7:0]              tx_byte_o,
  input  logic                    tx_ready_i,
  output logic                    done_o
);
  tx_state_e               state_q;
  logic [CNT_W-1:0]        remain_q;
  logic [IDX_W-1:0]        idx_q;
  logic [8*DATA_BYTES-1:0] grp_q;
  logic [7:0]              sum_q;
  logic                    done_q;

  logic [8*WIRE_BYTES-1:0] wire_bytes;
  logic [8*DATA_BYTES-1:0] grp_fixed;
  logic [7:0]              sum_next;
  logic                    pend;
  logic                    pend_clr;
  logic                    last_grp;
  logic                    last_wire;

  assign last_grp  = remain_q == CNT_W'(1);
  assign last_wire = idx_q == IDX_W'(WIRE_BYTES - 1);
  assign pend_clr  = (state_q == ST_IDLE) || (state_q == ST_GRAB && pend);

  resp_tx_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .link_i (link_i),
    .clr_i  (pend_clr),
    .pend_o (pend)
  );

  resp_tx_csum #(.DATA_BYTES(DATA_BYTES)) u_csum (
    .grp_i  (grp_data_i),
    .sum_i  (sum_q),
    .last_i (last_grp),
    .grp_o  (grp_fixed),
    .sum_o  (sum_next)
  );

  resp_tx_enc #(.DATA_BYTES(DATA_BYTES)) u_enc (
    .grp_i  (grp_q),
    .wire_o (wire_bytes)
  );

  assign grp_ready_o = (state_q == ST_GRAB) && !pend;
  assign tx_valid_o  = (state_q == ST_SYNC) || (state_q == ST_SEND);
  assign tx_byte_o   = (state_q == ST_SYNC) ? SYNC_BYTE : wire_bytes[8*idx_q +: 8];
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      idx_q    <= '0;
      grp_q    <= '0;
      sum_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i && n_groups_i != '0) begin
          remain_q <= n_groups_i;
          sum_q    <= '0;
          state_q  <= ST_SYNC;
        end
        ST_SYNC: if (tx_ready_i) state_q <= ST_GRAB;
        ST_GRAB: begin
          // suspend is honoured only between groups
          if (pend) state_q <= ST_PAUSE;
          else if (grp_valid_i) begin
            grp_q   <= grp_fixed;
            sum_q   <= sum_next;
            idx_q   <= '0;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: if (tx_ready_i) begin
          if (last_wire) begin
            remain_q <= remain_q - CNT_W'(1);
            state_q  <= last_grp ? ST_IDLE : ST_GRAB;
            done_q   <= last_grp;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_PAUSE: if (link_i) state_q <= ST_SYNC;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/resp_tx_chk.sv
module resp_tx_chk #(
  parameter int DATA_BYTES = 7,
  parameter int CNT_W = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [CNT_W-1:0]        n_groups_i,
  input logic                    grp_valid_i,
  input logic [8*DATA_BYTES-1:0] grp_data_i,
  input logic                    grp_ready_o,
  input logic                    link_i,
  input logic                    tx_valid_o,
  input logic [7:0]              tx_byte_o,
  input logic                    tx_ready_i,
  input logic                    done_o
);
  // R11
  msb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_byte_o[7]);

  // R11
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_byte_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_valid_o && !grp_ready_o);

  // R6
  one_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grp_ready_o && tx_valid_o));

  // R7
  fall_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_i) |=> !grp_ready_o);
endmodule

bind resp_tx resp_tx_chk #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .n_groups_i  (n_groups_i),
  .grp_valid_i (grp_valid_i),
  .grp_data_i  (grp_data_i),
  .grp_ready_o (grp_ready_o),
  .link_i      (link_i),
  .tx_valid_o  (tx_valid_o),
  .tx_byte_o   (tx_byte_o),
  .tx_ready_i  (tx_ready_i),
  .done_o      (done_o)
);

// File: tb/resp_tx_tb_top.sv
module resp_tx_tb_top;
  localparam int DB = 7;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] n_groups_i = '0;
  logic          grp_valid_i = 1'b0;
  logic [8*DB-1:0] grp_data_i = '0;
  logic          grp_ready_o;
  logic          link_i = 1'b1;
  logic          tx_valid_o;
  logic [7:0]    tx_byte_o;
  logic          tx_ready_i = 1'b0;
  logic          done_o;

  int total = 0;
  int bad = 0;
  bit all_done = 0;

  always #10 clk = ~clk;

  resp_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .n_groups_i(n_groups_i),
    .grp_valid_i(grp_valid_i), .grp_data_i(grp_data_i), .grp_ready_o(grp_ready_o),
    .link_i(link_i), .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
    .tx_ready_i(tx_ready_i), .done_o(done_o)
  );

  // {n[24:17], seed[16:9], stall[8], hold_group[7:0] (FF = none)}
  localparam logic [24:0] VECS [6] = '{
    {8'd3,  8'h11, 1'b0, 8'hFF},
    {8'd5,  8'h40, 1'b1, 8'd1},
    {8'd49, 8'h07, 1'b1, 8'd20},
    {8'd1,  8'hF3, 1'b0, 8'hFF},
    {8'd4,  8'h9C, 1'b0, 8'd3},
    {8'd2,  8'h00, 1'b1, 8'd0}
  };

  logic [7:0] got [512];
  logic [7:0] exp [512];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int g, input int k);
    return 8'(int'(seed) + g * 7 + k * 29 + g * k * 3);
  endfunction

  task automatic run_frame(input logic [24:0] v);
    int n = int'(v[24:17]);
    logic [7:0] seed = v[16:9];
    bit stall = v[8];
    bit hold = v[7:0] != 8'hFF;
    int hg = int'(v[7:0]);
    bit ins = hold && (hg + 1 < n);
    int bpos = 1 + 8 * (hg + 1);
    int elen = 1 + 8 * n + (ins ? 1 : 0);
    int na = 0, gh = 0, dn = 0, post = 0, quiet = 0, lowc = 0, mism = 0, first_bad = -1;
    bit dropped = 0;
    bit fin = 0;
    logic [7:0] sum = 0;
    int p = 0;

    // expected stream
    exp[p++] = 8'hAA;
    for (int g = 0; g < n; g++) begin
      logic [7:0] d [7];
      logic [7:0] hd = 8'h80;
      if (ins && g == hg + 1) exp[p++] = 8'hAA;
      for (int k = 0; k < 7; k++) begin
        d[k] = (g == n - 1 && k == 6) ? 8'(-sum) : dbyte(seed, g, k);
        sum = sum + d[k];
        hd[6-k] = d[k][7];
      end
      exp[p++] = hd;
      for (int k = 0; k < 7; k++) exp[p++] = {1'b1, d[k][6:0]};
    end

    grp_valid_i = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (done_o) dn++;
      start_i = (cyc == 0);
      n_groups_i = CW'(n);
      tx_ready_i = stall ? (cyc % 3 != 1) : 1'b1;
      if (hold && !dropped && na == 1 + 8 * hg + 3) begin
        dropped = 1;
        link_i = 1'b0;
      end
      if (!link_i) begin
        lowc++;
        if (lowc > 25) link_i = 1'b1;
      end
      for (int k = 0; k < 7; k++)
        grp_data_i[8*k +: 8] = (gh == n - 1 && k == 6) ? 8'h5A : dbyte(seed, gh, k);
      if (!link_i && na >= bpos && tx_valid_o) quiet++;
      if (tx_valid_o && tx_ready_i) begin
        if (na < 512) got[na] = tx_byte_o;
        na++;
      end
      if (grp_ready_o && grp_valid_i) gh++;
      if (dn > 0) post++;
      if (post >= 8) begin
        fin = 1;
        break;
      end
    end
    start_i = 1'b0;
    grp_valid_i = 1'b0;
    link_i = 1'b1;

    chk(fin, "R10 frame finished", int'(fin), 1);
    chk(got[0] == 8'hAA, "R3 leading sync", int'(got[0]), 8'hAA);
    chk(na == elen, "R3 R9 wire byte count", na, elen);
    for (int k = 0; k < elen && k < 512; k++)
      if (got[k] !== exp[k]) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
    chk(mism == 0, ins ? "R4 R8 stream with resync" : "R4 stream", first_bad, -1);
    chk(gh == n, "R6 groups taken", gh, n);
    chk(dn == 1, "R10 done pulses", dn, 1);
    if (hold) chk(quiet == 0, "R7 silent while suspended", quiet, 0);

    // decode received payload and sum it
    sum = 0;
    p = 1;
    for (int g = 0; g < n && p + 8 <= 512; g++) begin
      if (ins && g == hg + 1) p++;
      for (int k = 0; k < 7; k++) sum = sum + {got[p][6-k], got[p+1+k][6:0]};
      p += 8;
    end
    chk(sum == 8'h00, "R5 payload sum", int'(sum), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_valid_o == 1'b0, "R1 tx_valid after reset", int'(tx_valid_o), 0);
    chk(grp_ready_o == 1'b0, "R1 grp_ready after reset", int'(grp_ready_o), 0);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) run_frame(VECS[i]);

    // R2: zero count start must send nothing
    begin
      int seen = 0;
      @(negedge clk);
      start_i = 1'b1;
      n_groups_i = '0;
      tx_ready_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < 12; c++) begin
        if (tx_valid_o || grp_ready_o || done_o) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R2 zero count ignored", seen, 0);
    end

    // R2: a later nonzero start still works
    run_frame({8'd2, 8'h66, 1'b0, 8'hFF});

    all_done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule